// File: doc/BRIEF.md
# Multi-Word Micro-Operation Sequencer

This block sits at the issue stage of a core whose register file offers two read ports and a single write port. Any decoded instruction that needs a second register write, or more operand reads than the ports allow in one cycle, is accepted here and unrolled into a sequence of micro-operations, one per clock. Covered instruction classes are multi-register loads and stores with a word count, double-word loads and stores, paired register moves, shift-then-ALU operations, stores addressed by base plus index register, and loads that also rewrite their base register.

The decoder offers an instruction with a valid/ready handshake. Once it is taken, the block emits each micro-operation with its kind, register indices, write enable, word address, position tag and first/last markers. It holds `busy` high, and `in_ready` low, until the final micro-operation is on its outputs. This lets the next instruction be taken in the same cycle that the previous one finishes.

Top module: `mop_sequencer`

## Requirements
- R1: After reset `uop_valid` and `busy` are 0 and `in_ready` is 1. While idle every micro-operation output field is 0.
- R2: An instruction of kind 0 (plain) yields one micro-operation of kind 0 with rd, ra and rb passed through, `uop_we`=1 and address 0, marked first and last. `in_ready` is 1 in that same cycle, so a second plain instruction offered then is issued in the next cycle.
- R3: A kind 1 load yields a kind 1 micro-operation (rd written, ra as base, address as given). When `in_base_upd` is 1, a kind 3 base-update micro-operation follows that writes ra and carries the address plus 4.
- R4: A kind 2 load-multiple of N words yields N kind 1 micro-operations. Destination registers ascend from rd and wrap modulo the register count, and the address steps by 4 per word. A count of 0 is taken as 1, and a count above 12 is taken as 12.
- R5: With `in_base_upd` set on a multi-word transfer, one extra kind 3 micro-operation is appended at index N. It writes ra and carries the start address plus 4N.
- R6: A kind 3 store-multiple yields N kind 2 micro-operations. Each reads the data register rd+i on rb, has `uop_we`=0 and rd=0, and steps the address by 4.
- R7: Double-word load (kind 4) and store (kind 5) behave as counts of 2 whatever `in_count` holds, including the appended base update.
- R8: A kind 6 paired move yields two kind 4 micro-operations. The first writes the even register of the rd pair from the even register of the ra pair. The second uses the odd registers.
- R9: A kind 7 shift-then-ALU yields a kind 5 shift that reads rb and writes nothing, then a kind 6 ALU step that reads ra and writes rd.
- R10: A kind 8 indexed store yields a kind 7 address step reading ra and rb, then a kind 8 data step reading rd on rb. Neither step writes.
- R11: While an instruction still has micro-operations after the current one, `busy` is 1 and `in_ready` is 0. An instruction offered then is not taken until the last micro-operation, and it is issued in the next cycle.
- R12: Each micro-operation carries its index from 0 upward in `uop_idx`. `uop_first` marks index 0 and `uop_last` marks the final step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Decoded instruction offered |
| in_ready | output | 1 | Instruction can be taken this cycle |
| in_kind | input | 4 | Instruction class code |
| in_rd | input | REG_W (5) | Destination or first data register |
| in_ra | input | REG_W (5) | Base or first source register |
| in_rb | input | REG_W (5) | Second source or index register |
| in_count | input | COUNT_W (4) | Word count of a multi-word transfer |
| in_base_upd | input | 1 | Base register is rewritten after the transfer |
| in_addr | input | ADDR_W (32) | Start word address |
| uop_valid | output | 1 | A micro-operation is presented |
| uop_kind | output | 4 | Micro-operation class code |
| uop_rd | output | REG_W (5) | Register written |
| uop_ra | output | REG_W (5) | First register read |
| uop_rb | output | REG_W (5) | Second register read |
| uop_we | output | 1 | Register write enable |
| uop_addr | output | ADDR_W (32) | Word address of a memory step |
| uop_idx | output | IDX_W (4) | Position of this step in its instruction |
| uop_first | output | 1 | First step of the instruction |
| uop_last | output | 1 | Last step of the instruction |
| busy | output | 1 | More steps of the current instruction follow |

## Verification
The bench builds the block with its defaults: 5-bit register indices, a 12-word transfer limit and a 4-byte word. With these values a 12-word load with base update reaches 13 steps, so the last index fills the 4-bit tag. A transfer starting at register 30 shows the wrap to register 0. The power-of-two word size selects the shift variant of the address stepping. The cases cover the clamps on count 0 and on the double-word kinds, and an instruction that waits at the input while a multi-word transfer drains.

// File: rtl/mop_seq_pkg.sv
package mop_seq_pkg;

   // instruction classes accepted from decode
   typedef enum logic [3:0] {
      IK_PLAIN  = 4'd0,
      IK_LOAD   = 4'd1,
      IK_LDMULT = 4'd2,
      IK_STMULT = 4'd3,
      IK_LDDBL  = 4'd4,
      IK_STDBL  = 4'd5,
      IK_MOVPR  = 4'd6,
      IK_SHALU  = 4'd7,
      IK_STIDX  = 4'd8
   } instr_kind_e;

   // micro-operation classes sent down the pipe
   typedef enum logic [3:0] {
      UK_PASS   = 4'd0,
      UK_LOAD   = 4'd1,
      UK_STORE  = 4'd2,
      UK_BASE   = 4'd3,
      UK_MOVE   = 4'd4,
      UK_SHIFT  = 4'd5,
      UK_ALU    = 4'd6,
      UK_AGEN   = 4'd7,
      UK_STDATA = 4'd8
   } uop_kind_e;

endpackage

// File: rtl/mop_plan.sv
// Works out how many micro-operations an incoming instruction needs.
module mop_plan
   import mop_seq_pkg::*;
#(
   parameter int MAX_WORDS = 12,
   parameter int COUNT_W   = 4,
   parameter int IW        = 4
) (
   input  logic [3:0]         kind,
   input  logic [COUNT_W-1:0] count,
   input  logic               base_upd,
   output logic [IW-1:0]      n_uops,
   output logic [IW-1:0]      words
);

   logic [IW-1:0] clamp_w;
   logic [IW-1:0] upd_w;

   always_comb begin
      if (count == '0)
         clamp_w = IW'(1);
      else if (int'(count) > MAX_WORDS)
         clamp_w = IW'(MAX_WORDS);
      else
         clamp_w = IW'(count);
   end

   assign upd_w = base_upd ? IW'(1) : '0;

   always_comb begin
      words  = '0;
      n_uops = IW'(1);
      case (instr_kind_e'(kind))
         IK_LOAD: begin
            words  = IW'(1);
            n_uops = IW'(1) + upd_w;
         end
         IK_LDMULT, IK_STMULT: begin
            words  = clamp_w;
            n_uops = clamp_w + upd_w;
         end
         IK_LDDBL, IK_STDBL: begin
            words  = IW'(2);
            n_uops = IW'(2) + upd_w;
         end
         IK_MOVPR, IK_SHALU, IK_STIDX: begin
            n_uops = IW'(2);
         end
         default: begin
            n_uops = IW'(1);
         end
      endcase
   end

endmodule

// File: rtl/mop_step.sv
// Step counter: tracks the position inside the current instruction.
module mop_step #(
   parameter int IW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [IW-1:0] n_in,
   output logic          active,
   output logic [IW-1:0] idx,
   output logic          last
);

   logic [IW-1:0] n_q;

   assign last = active && (idx == n_q - IW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         idx    <= '0;
         n_q    <= IW'(1);
      end else if (start) begin
         active <= 1'b1;
         idx    <= '0;
         n_q    <= n_in;
      end else if (last) begin
         active <= 1'b0;
         idx    <= '0;
      end else if (active) begin
         idx    <= idx + IW'(1);
      end
   end

   // R12
   idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !last && !start) |=> (active && idx == $past(idx) + IW'(1)));

   // R12
   idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> (idx < n_q));

endmodule

// File: rtl/mop_gen.sv
// Builds the fields of one micro-operation from the held instruction and step index.
module mop_gen
   import mop_seq_pkg::*;
#(
   parameter int REG_W      = 5,
   parameter int ADDR_W     = 32,
   parameter int WORD_BYTES = 4,
   parameter int IW         = 4
) (
   input  logic [3:0]        h_kind,
   input  logic [REG_W-1:0]  h_rd,
   input  logic [REG_W-1:0]  h_ra,
   input  logic [REG_W-1:0]  h_rb,
   input  logic [ADDR_W-1:0] h_addr,
   input  logic [IW-1:0]     h_words,
   input  logic [IW-1:0]     idx,
   output logic [3:0]        g_kind,
   output logic [REG_W-1:0]  g_rd,
   output logic [REG_W-1:0]  g_ra,
   output logic [REG_W-1:0]  g_rb,
   output logic              g_we,
   output logic [ADDR_W-1:0] g_addr
);

   localparam bit POW2 = (WORD_BYTES & (WORD_BYTES - 1)) == 0;

   logic [ADDR_W-1:0] offset;
   logic [REG_W-1:0]  reg_step;
   logic [REG_W-1:0]  rd_even;
   logic [REG_W-1:0]  ra_even;
   logic              in_data;

   generate
      if (POW2) begin : gen_shift_off
         localparam int SH = $clog2(WORD_BYTES);
         assign offset = ADDR_W'(idx) << SH;
      end else begin : gen_mul_off
         assign offset = ADDR_W'(idx) * ADDR_W'(WORD_BYTES);
      end
   endgenerate

   assign reg_step = h_rd + REG_W'(idx);
   assign rd_even  = {h_rd[REG_W-1:1], 1'b0};
   assign ra_even  = {h_ra[REG_W-1:1], 1'b0};
   assign in_data  = idx < h_words;

   always_comb begin
      g_kind = UK_PASS;
      g_rd   = '0;
      g_ra   = '0;
      g_rb   = '0;
      g_we   = 1'b0;
      g_addr = '0;
      case (instr_kind_e'(h_kind))
         IK_LOAD, IK_LDMULT, IK_LDDBL: begin
            g_ra   = h_ra;
            g_we   = 1'b1;
            g_addr = h_addr + offset;
            if (in_data) begin
               g_kind = UK_LOAD;
               g_rd   = reg_step;
            end else begin
               g_kind = UK_BASE;
               g_rd   = h_ra;
            end
         end
         IK_STMULT, IK_STDBL: begin
            g_ra   = h_ra;
            g_addr = h_addr + offset;
            if (in_data) begin
               g_kind = UK_STORE;
               g_rb   = reg_step;
            end else begin
               g_kind = UK_BASE;
               g_rd   = h_ra;
               g_we   = 1'b1;
            end
         end
         IK_MOVPR: begin
            g_kind = UK_MOVE;
            g_we   = 1'b1;
            g_rd   = rd_even | REG_W'(idx[0]);
            g_ra   = ra_even | REG_W'(idx[0]);
         end
         IK_SHALU: begin
            if (idx == '0) begin
               g_kind = UK_SHIFT;
               g_rb   = h_rb;
            end else begin
               g_kind = UK_ALU;
               g_ra   = h_ra;
               g_rd   = h_rd;
               g_we   = 1'b1;
            end
         end
         IK_STIDX: begin
            if (idx == '0) begin
               g_kind = UK_AGEN;
               g_ra   = h_ra;
               g_rb   = h_rb;
            end else begin
               g_kind = UK_STDATA;
               g_rb   = h_rd;
            end
         end
         default: begin
            g_kind = UK_PASS;
            g_rd   = h_rd;
            g_ra   = h_ra;
            g_rb   = h_rb;
            g_we   = 1'b1;
         end
      endcase
   end

endmodule

// File: rtl/mop_sequencer.sv
module mop_sequencer
   import mop_seq_pkg::*;
#(
   parameter int  REG_W      = 5,
   parameter int  ADDR_W     = 32,
   parameter int  COUNT_W    = 4,
   parameter int  MAX_WORDS  = 12,
   parameter int  WORD_BYTES = 4,
   localparam int IDX_W      = $clog2(MAX_WORDS + 2)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   output logic               in_ready,
   input  logic [3:0]         in_kind,
   input  logic [REG_W-1:0]   in_rd,
   input  logic [REG_W-1:0]   in_ra,
   input  logic [REG_W-1:0]   in_rb,
   input  logic [COUNT_W-1:0] in_count,
   input  logic               in_base_upd,
   input  logic [ADDR_W-1:0]  in_addr,
   output logic               uop_valid,
   output logic [3:0]         uop_kind,
   output logic [REG_W-1:0]   uop_rd,
   output logic [REG_W-1:0]   uop_ra,
   output logic [REG_W-1:0]   uop_rb,
   output logic               uop_we,
   output logic [ADDR_W-1:0]  uop_addr,
   output logic [IDX_W-1:0]   uop_idx,
   output logic               uop_first,
   output logic               uop_last,
   output logic               busy
);

   // elaboration-time parameter checks
   generate
      if (REG_W < 2) begin : gen_bad_reg
         $error("REG_W must be at least 2");
      end
      if (MAX_WORDS < 2 || MAX_WORDS >= (1 << COUNT_W)) begin : gen_bad_max
         $error("MAX_WORDS must be at least 2 and fit COUNT_W");
      end
      if (WORD_BYTES < 1) begin : gen_bad_word
         $error("WORD_BYTES must be positive");
      end
   endgenerate

   logic               start;
   logic               active;
   logic               last;
   logic [IDX_W-1:0]   idx;
   logic [IDX_W-1:0]   plan_n;
   logic [IDX_W-1:0]   plan_words;

   logic [3:0]         h_kind;
   logic [REG_W-1:0]   h_rd, h_ra, h_rb;
   logic [ADDR_W-1:0]  h_addr;
   logic [IDX_W-1:0]   h_words;

   logic [3:0]         g_kind;
   logic [REG_W-1:0]   g_rd, g_ra, g_rb;
   logic               g_we;
   logic [ADDR_W-1:0]  g_addr;

   assign busy     = active && !last;
   assign in_ready = !busy;
   assign start    = in_valid && in_ready;

   mop_plan #(
      .MAX_WORDS (MAX_WORDS),
      .COUNT_W   (COUNT_W),
      .IW        (IDX_W)
   ) u_plan (
      .kind      (in_kind),
      .count     (in_count),
      .base_upd  (in_base_upd),
      .n_uops    (plan_n),
      .words     (plan_words)
   );

   mop_step #(
      .IW        (IDX_W)
   ) u_step (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .n_in      (plan_n),
      .active    (active),
      .idx       (idx),
      .last      (last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         h_kind  <= '0;
         h_rd    <= '0;
         h_ra    <= '0;
         h_rb    <= '0;
         h_addr  <= '0;
         h_words <= '0;
      end else if (start) begin
         h_kind  <= in_kind;
         h_rd    <= in_rd;
         h_ra    <= in_ra;
         h_rb    <= in_rb;
         h_addr  <= in_addr;
         h_words <= plan_words;
      end
   end

   mop_gen #(
      .REG_W      (REG_W),
      .ADDR_W     (ADDR_W),
      .WORD_BYTES (WORD_BYTES),
      .IW         (IDX_W)
   ) u_gen (
      .h_kind    (h_kind),
      .h_rd      (h_rd),
      .h_ra      (h_ra),
      .h_rb      (h_rb),
      .h_addr    (h_addr),
      .h_words   (h_words),
      .idx       (idx),
      .g_kind    (g_kind),
      .g_rd      (g_rd),
      .g_ra      (g_ra),
      .g_rb      (g_rb),
      .g_we      (g_we),
      .g_addr    (g_addr)
   );

   assign uop_valid = active;
   assign uop_kind  = active ? g_kind : '0;
   assign uop_rd    = active ? g_rd   : '0;
   assign uop_ra    = active ? g_ra   : '0;
   assign uop_rb    = active ? g_rb   : '0;
   assign uop_we    = active && g_we;
   assign uop_addr  = active ? g_addr : '0;
   assign uop_idx   = active ? idx    : '0;
   assign uop_first = active && (idx == '0);
   assign uop_last  = last;

   // R12
   rise_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(uop_valid) |-> uop_first);

   // R12
   after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (uop_valid && uop_last) |=> (!uop_valid || uop_first));

   // R11
   busy_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> (uop_valid && !uop_first));

   // R4
   addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (uop_valid && !uop_last &&
       (uop_kind == UK_LOAD || uop_kind == UK_STORE))
      |=> (uop_kind == UK_BASE ||
           uop_addr == $past(uop_addr) + ADDR_W'(WORD_BYTES)));

   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !uop_valid |-> (!uop_we && !busy));

endmodule

// File: tb/mop_sequencer_test.sv
`timescale 1ns/1ps
module mop_sequencer_test;
   import mop_seq_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [3:0]  in_kind = '0;
   logic [4:0]  in_rd = '0, in_ra = '0, in_rb = '0;
   logic [3:0]  in_count = '0;
   logic        in_base_upd = 1'b0;
   logic [31:0] in_addr = '0;
   logic        uop_valid;
   logic [3:0]  uop_kind;
   logic [4:0]  uop_rd, uop_ra, uop_rb;
   logic        uop_we;
   logic [31:0] uop_addr;
   logic [3:0]  uop_idx;
   logic        uop_first, uop_last, busy;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;

   always #2 clk = ~clk;

   mop_sequencer uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_kind(in_kind), .in_rd(in_rd), .in_ra(in_ra), .in_rb(in_rb),
      .in_count(in_count), .in_base_upd(in_base_upd), .in_addr(in_addr),
      .uop_valid(uop_valid), .uop_kind(uop_kind), .uop_rd(uop_rd),
      .uop_ra(uop_ra), .uop_rb(uop_rb), .uop_we(uop_we), .uop_addr(uop_addr),
      .uop_idx(uop_idx), .uop_first(uop_first), .uop_last(uop_last), .busy(busy)
   );

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 20000) begin
         checks = checks + 1;
         fails  = fails + 1;
         $display("FAIL watchdog: run hung, actual cycles=%0d expected < 20000", cycles);
         summary();
      end
   end

   task automatic check_bit(string rq, logic act, logic exp);
      checks = checks + 1;
      if (act !== exp) begin
         fails = fails + 1;
         $display("FAIL %s: actual=%0b expected=%0b", rq, act, exp);
      end
   endtask

   task automatic offer(logic [3:0] k, logic [4:0] rd, logic [4:0] ra, logic [4:0] rb,
                        logic [3:0] cnt, logic upd, logic [31:0] addr);
      in_kind = k; in_rd = rd; in_ra = ra; in_rb = rb;
      in_count = cnt; in_base_upd = upd; in_addr = addr;
      in_valid = 1'b1;
   endtask

   // offers at a negedge, returns at the negedge where step 0 is visible
   task automatic issue(logic [3:0] k, logic [4:0] rd, logic [4:0] ra, logic [4:0] rb,
                        logic [3:0] cnt, logic upd, logic [31:0] addr);
      @(negedge clk);
      offer(k, rd, ra, rb, cnt, upd, addr);
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   // compares the visible micro-operation, then advances one cycle
   task automatic expect_uop(string rq, uop_kind_e k, int rd, int ra, int rb, int we,
                             int addr, int idx, int first, int last);
      logic [31:0] act [10];
      logic [31:0] exp [10];
      logic bad;
      act = '{32'(uop_valid), 32'(uop_kind), 32'(uop_rd), 32'(uop_ra), 32'(uop_rb),
              32'(uop_we), uop_addr, 32'(uop_idx), 32'(uop_first), 32'(uop_last)};
      exp = '{32'd1, 32'(k), 32'(rd), 32'(ra), 32'(rb), 32'(we), 32'(addr),
              32'(idx), 32'(first), 32'(last)};
      bad = 1'b0;
      for (int i = 0; i < 10; i++) if (act[i] !== exp[i]) bad = 1'b1;
      checks = checks + 1;
      if (bad) begin
         fails = fails + 1;
         $display("FAIL %s: actual v=%0d k=%0d rd=%0d ra=%0d rb=%0d we=%0d a=%0h i=%0d f=%0d l=%0d expected v=%0d k=%0d rd=%0d ra=%0d rb=%0d we=%0d a=%0h i=%0d f=%0d l=%0d",
                  rq, act[0], act[1], act[2], act[3], act[4], act[5], act[6], act[7], act[8], act[9],
                  exp[0], exp[1], exp[2], exp[3], exp[4], exp[5], exp[6], exp[7], exp[8], exp[9]);
      end
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic expect_idle(string rq);
      checks = checks + 1;
      if (uop_valid !== 1'b0 || in_ready !== 1'b1 || busy !== 1'b0 ||
          uop_kind !== '0 || uop_rd !== '0 || uop_addr !== '0) begin
         fails = fails + 1;
         $display("FAIL %s: actual valid=%0b ready=%0b busy=%0b kind=%0d rd=%0d addr=%0h expected 0 1 0 0 0 0",
                  rq, uop_valid, in_ready, busy, uop_kind, uop_rd, uop_addr);
      end
   endtask

   task automatic t_reset();
      expect_idle("R1 reset state");
   endtask

   task automatic t_plain();
      issue(4'd0, 5'd3, 5'd4, 5'd5, 4'd0, 1'b0, 32'h100);
      check_bit("R2 ready with single step", in_ready, 1'b1);
      expect_uop("R2 plain", UK_PASS, 3, 4, 5, 1, 0, 0, 1, 1);
      expect_idle("R2 released");
      // back to back
      @(negedge clk);
      offer(4'd0, 5'd1, 5'd2, 5'd3, 4'd0, 1'b0, 32'h0);
      @(posedge clk);
      @(negedge clk);
      offer(4'd0, 5'd9, 5'd10, 5'd11, 4'd0, 1'b0, 32'h0);
      expect_uop("R2 back-to-back first", UK_PASS, 1, 2, 3, 1, 0, 0, 1, 1);
      in_valid = 1'b0;
      expect_uop("R2 back-to-back second", UK_PASS, 9, 10, 11, 1, 0, 0, 1, 1);
      expect_idle("R2 idle after pair");
   endtask

   task automatic t_load();
      issue(4'd1, 5'd7, 5'd2, 5'd0, 4'd0, 1'b1, 32'h40);
      expect_uop("R3 load step", UK_LOAD, 7, 2, 0, 1, 'h40, 0, 1, 0);
      expect_uop("R3 base update", UK_BASE, 2, 2, 0, 1, 'h44, 1, 0, 1);
      issue(4'd1, 5'd8, 5'd6, 5'd0, 4'd0, 1'b0, 32'h80);
      expect_uop("R3 load no update", UK_LOAD, 8, 6, 0, 1, 'h80, 0, 1, 1);
      expect_idle("R3 idle");
   endtask

   task automatic ldm(string rq, int rd, int ra, int n, int upd, int addr);
      issue(4'd2, 5'(rd), 5'(ra), 5'd0, 4'(n), 1'(upd), 32'(addr));
      for (int i = 0; i < n; i++)
         expect_uop(rq, UK_LOAD, (rd + i) % 32, ra, 0, 1, addr + 4 * i, i,
                    i == 0, (i == n - 1) && upd == 0);
      if (upd != 0)
         expect_uop("R5 appended base", UK_BASE, ra, ra, 0, 1, addr + 4 * n, n, 0, 1);
   endtask

   task automatic t_ldm();
      ldm("R4 three words wrap", 30, 5, 3, 0, 'h1000);
      ldm("R4 eight words", 1, 9, 8, 1, 'h2000);
      ldm("R4 twelve words", 4, 3, 12, 1, 'h3000);
      issue(4'd2, 5'd17, 5'd2, 5'd0, 4'd0, 1'b0, 32'h500);
      expect_uop("R4 count 0 as 1", UK_LOAD, 17, 2, 0, 1, 'h500, 0, 1, 1);
      issue(4'd2, 5'd0, 5'd2, 5'd0, 4'd15, 1'b0, 32'h600);
      for (int i = 0; i < 12; i++)
         expect_uop("R4 count 15 as 12", UK_LOAD, i, 2, 0, 1, 'h600 + 4 * i, i, i == 0, i == 11);
      expect_idle("R4 idle after clamp");
   endtask

   task automatic t_stm();
      issue(4'd3, 5'd10, 5'd1, 5'd0, 4'd4, 1'b1, 32'h700);
      for (int i = 0; i < 4; i++)
         expect_uop("R6 store multiple", UK_STORE, 0, 1, 10 + i, 0, 'h700 + 4 * i, i, i == 0, 0);
      expect_uop("R5 store base update", UK_BASE, 1, 1, 0, 1, 'h710, 4, 0, 1);
   endtask

   task automatic t_double();
      issue(4'd4, 5'd6, 5'd9, 5'd0, 4'd5, 1'b1, 32'h900);
      expect_uop("R7 double load w0", UK_LOAD, 6, 9, 0, 1, 'h900, 0, 1, 0);
      expect_uop("R7 double load w1", UK_LOAD, 7, 9, 0, 1, 'h904, 1, 0, 0);
      expect_uop("R7 double load base", UK_BASE, 9, 9, 0, 1, 'h908, 2, 0, 1);
      issue(4'd5, 5'd20, 5'd3, 5'd0, 4'd0, 1'b0, 32'hA00);
      expect_uop("R7 double store w0", UK_STORE, 0, 3, 20, 0, 'hA00, 0, 1, 0);
      expect_uop("R7 double store w1", UK_STORE, 0, 3, 21, 0, 'hA04, 1, 0, 1);
      expect_idle("R7 idle");
   endtask

   task automatic t_move();
      issue(4'd6, 5'd13, 5'd21, 5'd0, 4'd0, 1'b0, 32'h0);
      expect_uop("R8 move even", UK_MOVE, 12, 20, 0, 1, 0, 0, 1, 0);
      expect_uop("R8 move odd", UK_MOVE, 13, 21, 0, 1, 0, 1, 0, 1);
   endtask

   task automatic t_shalu();
      issue(4'd7, 5'd8, 5'd9, 5'd10, 4'd0, 1'b0, 32'h0);
      expect_uop("R9 shift step", UK_SHIFT, 0, 0, 10, 0, 0, 0, 1, 0);
      expect_uop("R9 alu step", UK_ALU, 8, 9, 0, 1, 0, 1, 0, 1);
   endtask

   task automatic t_stidx();
      issue(4'd8, 5'd11, 5'd12, 5'd13, 4'd0, 1'b0, 32'h0);
      expect_uop("R10 address step", UK_AGEN, 0, 12, 13, 0, 0, 0, 1, 0);
      expect_uop("R10 data step", UK_STDATA, 0, 0, 11, 0, 0, 1, 0, 1);
   endtask

   task automatic t_busy();
      issue(4'd2, 5'd1, 5'd2, 5'd0, 4'd3, 1'b0, 32'h200);
      check_bit("R11 busy during transfer", busy, 1'b1);
      check_bit("R11 not ready during transfer", in_ready, 1'b0);
      offer(4'd0, 5'd20, 5'd21, 5'd22, 4'd0, 1'b0, 32'h0);
      expect_uop("R11 held w0", UK_LOAD, 1, 2, 0, 1, 'h200, 0, 1, 0);
      expect_uop("R11 held w1", UK_LOAD, 2, 2, 0, 1, 'h204, 1, 0, 0);
      check_bit("R11 ready on last", in_ready, 1'b1);
      check_bit("R11 busy clear on last", busy, 1'b0);
      expect_uop("R11 held w2", UK_LOAD, 3, 2, 0, 1, 'h208, 2, 0, 1);
      in_valid = 1'b0;
      expect_uop("R11 waiting instr issued", UK_PASS, 20, 21, 22, 1, 0, 0, 1, 1);
      expect_idle("R11 idle");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_plain();
      t_load();
      t_ldm();
      t_stm();
      t_double();
      t_move();
      t_shalu();
      t_stidx();
      t_busy();
      repeat (2) @(negedge clk);
      summary();
   end

endmodule